// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Flags

This block holds a bank of token flags that two independent requesters, a left port and a right port, use to build mutual exclusion in software. Each port picks one flag with a small index, then either writes to it to ask for or give back the token, or reads it to learn whether it currently holds that token. A port addresses the flags only when its memory enable is inactive (high) and its flag-select strobe is active (low).

A write whose data bit 0 is zero asks for the token; a write whose bit 0 is one gives it back. The token goes to the asker at once when the flag is free. When the other side holds it, the request is remembered, and the token moves across as soon as the holder gives it back. A requester that changes its mind can withdraw by writing one. When both sides ask for a free flag in the same cycle, a per-flag tie pointer picks the winner and flips, so repeated ties alternate. State changes on the rising clock edge; reads are combinational from the registered state.

Top module: `sem_flags`

## Requirements
- R1: After reset every flag is free with no request pending and every flag's tie pointer favours the left port; both ports then read all ones from every flag.
- R2: A port accesses the flags only while its en input is 1 and its sel_n input is 0, and writes only when we is also 1; otherwise its stimulus changes no flag and its rdat output is all ones.
- R3: A read by an accessing port returns all DATA_W bits 0 when that port holds the selected flag and all bits 1 otherwise, taken from the state before the clock edge of any same-cycle write.
- R4: No flag is ever held by both ports at once.
- R5: A write with bit 0 equal to 0 to a free flag, with no write from the other port to that flag in the same cycle, gives the writer the token from the next cycle on.
- R6: A write of 0 to a flag held by the other port leaves ownership unchanged and records a pending request for the writer.
- R7: When the holder writes 1 while the other port has a pending request, or writes 0 to that flag in the same cycle, the token passes to the other port in the next cycle and its pending request is cleared.
- R8: When the holder writes 1 and no request from the other port is pending or arriving (including one withdrawn in that cycle), the flag becomes free.
- R9: A write of 1 from a port with a pending request withdraws the request, so a later release by the holder frees the flag.
- R10: When both ports write 0 to the same free flag in the same cycle, the left port wins if that flag's tie pointer is 0 and the right port wins if it is 1; the loser's request becomes pending and the pointer inverts.
- R11: A write of 1 from a port that neither holds nor requests the flag, and a write of 0 from the holder, change nothing.
- R12: Only data bit 0 of a write matters, and a write changes only the flag selected by its index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_en | input | 1 | Left memory enable; must be 1 to reach the flags |
| l_sel_n | input | 1 | Left flag select, active low |
| l_we | input | 1 | Left write enable, 1 = write |
| l_idx | input | IDX_W | Left flag index |
| l_wdat | input | DATA_W | Left write data; bit 0 used |
| l_rdat | output | DATA_W | Left read data |
| r_en | input | 1 | Right memory enable; must be 1 to reach the flags |
| r_sel_n | input | 1 | Right flag select, active low |
| r_we | input | 1 | Right write enable, 1 = write |
| r_idx | input | IDX_W | Right flag index |
| r_wdat | input | DATA_W | Right write data; bit 0 used |
| r_rdat | output | DATA_W | Right read data |

## Verification
A corrupted holder or pending bit appears at the ports only through reads, and only for the flag it lives in: a wrong holder bit flips the all-zero/all-one pattern a port reads from that flag in the same cycle, while a lost or spurious pending request stays invisible until the holder gives the token back and the flag then reads free instead of passing across, or the reverse. The tie pointer shows itself only on the next simultaneous request to the same flag. The bench therefore reads every flag from both ports after a long mixed sequence of requests, releases, withdrawals and ties, so that a hidden pending bit or pointer error is forced into a visible ownership difference within a few steps.

// File: rtl/sem_flags.sv
module sem_flags #(
  parameter int FLAGS  = 8,
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(FLAGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_en,
  input  logic              l_sel_n,
  input  logic              l_we,
  input  logic [IDX_W-1:0]  l_idx,
  input  logic [DATA_W-1:0] l_wdat,
  output logic [DATA_W-1:0] l_rdat,
  input  logic              r_en,
  input  logic              r_sel_n,
  input  logic              r_we,
  input  logic [IDX_W-1:0]  r_idx,
  input  logic [DATA_W-1:0] r_wdat,
  output logic [DATA_W-1:0] r_rdat
);

  logic [FLAGS-1:0] own_l, own_r, pend_l, pend_r, tie_r;

  wire l_acc = l_en & ~l_sel_n;
  wire r_acc = r_en & ~r_sel_n;
  wire l_wr  = l_acc & l_we;
  wire r_wr  = r_acc & r_we;

  assign l_rdat = (l_acc & own_l[l_idx]) ? '0 : '1;
  assign r_rdat = (r_acc & own_r[r_idx]) ? '0 : '1;

  for (genvar i = 0; i < FLAGS; i++) begin : g_flag
    wire hit_l = l_wr & (l_idx == IDX_W'(i));
    wire hit_r = r_wr & (r_idx == IDX_W'(i));
    wire lreq  = hit_l & ~l_wdat[0];
    wire lrel  = hit_l &  l_wdat[0];
    wire rreq  = hit_r & ~r_wdat[0];
    wire rrel  = hit_r &  r_wdat[0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        own_l[i]  <= 1'b0;
        own_r[i]  <= 1'b0;
        pend_l[i] <= 1'b0;
        pend_r[i] <= 1'b0;
        tie_r[i]  <= 1'b0;
      end else if (own_l[i]) begin
        if (lrel) begin
          own_l[i]  <= 1'b0;
          own_r[i]  <= rreq | (pend_r[i] & ~rrel);
          pend_r[i] <= 1'b0;
        end else if (rreq) begin
          pend_r[i] <= 1'b1;
        end else if (rrel) begin
          pend_r[i] <= 1'b0;
        end
      end else if (own_r[i]) begin
        if (rrel) begin
          own_r[i]  <= 1'b0;
          own_l[i]  <= lreq | (pend_l[i] & ~lrel);
          pend_l[i] <= 1'b0;
        end else if (lreq) begin
          pend_l[i] <= 1'b1;
        end else if (lrel) begin
          pend_l[i] <= 1'b0;
        end
      end else if (lreq & rreq) begin
        own_l[i]  <= ~tie_r[i];
        own_r[i]  <=  tie_r[i];
        pend_l[i] <=  tie_r[i];
        pend_r[i] <= ~tie_r[i];
        tie_r[i]  <= ~tie_r[i];
      end else begin
        own_l[i] <= lreq;
        own_r[i] <= rreq;
      end
    end
  end

endmodule

module sem_flags_chk #(
  parameter int FLAGS  = 8,
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(FLAGS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              l_en,
  input logic              l_sel_n,
  input logic              l_we,
  input logic [IDX_W-1:0]  l_idx,
  input logic [DATA_W-1:0] l_wdat,
  input logic [DATA_W-1:0] l_rdat,
  input logic              r_en,
  input logic              r_sel_n,
  input logic              r_we,
  input logic [IDX_W-1:0]  r_idx,
  input logic [DATA_W-1:0] r_wdat,
  input logic [DATA_W-1:0] r_rdat,
  input logic [FLAGS-1:0]  own_l,
  input logic [FLAGS-1:0]  own_r,
  input logic [FLAGS-1:0]  pend_l,
  input logic [FLAGS-1:0]  pend_r
);

  wire lw = l_en & ~l_sel_n & l_we;
  wire rw = r_en & ~r_sel_n & r_we;
  wire same = rw & (r_idx == l_idx);

  // R1
  reset_free_chk: assert property (@(posedge clk)
    !rst_n |=> (own_l == '0 && own_r == '0 && pend_l == '0 && pend_r == '0));

  // R4
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own_l & own_r) == '0);

  // R6
  pend_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_l & ~own_r) == '0 && (pend_r & ~own_l) == '0);

  // R3
  rdat_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_rdat == '0 || l_rdat == '1) && (r_rdat == '0 || r_rdat == '1));

  // R4
  both_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_idx == r_idx) |-> !(l_rdat == '0 && r_rdat == '0));

  // R5
  grab_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lw && !l_wdat[0] && !own_l[l_idx] && !own_r[l_idx] && !same)
      |=> own_l[$past(l_idx)]);

  // R7
  handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lw && l_wdat[0] && own_l[l_idx] && pend_r[l_idx] && !same)
      |=> (own_r[$past(l_idx)] && !pend_r[$past(l_idx)]));

endmodule

bind sem_flags sem_flags_chk #(.FLAGS(FLAGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_en(l_en), .l_sel_n(l_sel_n), .l_we(l_we), .l_idx(l_idx), .l_wdat(l_wdat), .l_rdat(l_rdat),
  .r_en(r_en), .r_sel_n(r_sel_n), .r_we(r_we), .r_idx(r_idx), .r_wdat(r_wdat), .r_rdat(r_rdat),
  .own_l(own_l), .own_r(own_r), .pend_l(pend_l), .pend_r(pend_r)
);

// File: tb/tb_sem_flags.sv
`timescale 1ns/100ps
module tb_sem_flags;
  localparam int F = 8;
  localparam int W = 8;
  localparam int IW = 3;

  logic clk = 0, rst_n = 0;
  logic l_en, l_sel_n, l_we, r_en, r_sel_n, r_we;
  logic [IW-1:0] l_idx, r_idx;
  logic [W-1:0] l_wdat, r_wdat, l_rdat, r_rdat;

  int vecs = 0, bad = 0;
  bit done = 0;
  int m_own [F];
  bit m_pl [F], m_pr [F], m_tie [F];

  always #5 clk = ~clk;

  sem_flags #(.FLAGS(F), .DATA_W(W)) dut (.*);

  task automatic model(bit lw, int li, bit lb, bit rw, int ri, bit rb);
    for (int f = 0; f < F; f++) begin
      bit lq = lw && li == f && !lb, lr = lw && li == f && lb;
      bit rq = rw && ri == f && !rb, rr = rw && ri == f && rb;
      case (m_own[f])
        0: if (lq && rq) begin
             if (m_tie[f]) begin m_own[f] = 2; m_pl[f] = 1; end
             else begin m_own[f] = 1; m_pr[f] = 1; end
             m_tie[f] = !m_tie[f];
           end else if (lq) m_own[f] = 1;
           else if (rq) m_own[f] = 2;
        1: if (lr) begin m_own[f] = ((m_pr[f] && !rr) || rq) ? 2 : 0; m_pr[f] = 0; end
           else if (rq) m_pr[f] = 1;
           else if (rr) m_pr[f] = 0;
        default: if (rr) begin m_own[f] = ((m_pl[f] && !lr) || lq) ? 1 : 0; m_pl[f] = 0; end
           else if (lq) m_pl[f] = 1;
           else if (lr) m_pl[f] = 0;
      endcase
    end
  endtask

  task automatic cmp(string tag, string side, int f, logic [W-1:0] act, logic [W-1:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s flag %0d: got %h expected %h", tag, side, f, act, exp);
    end
  endtask

  task automatic rd(int f, string tag);
    l_we = 0; r_we = 0; l_en = 1; r_en = 1; l_sel_n = 0; r_sel_n = 0;
    l_idx = IW'(f); r_idx = IW'(f);
    #1;
    cmp(tag, "left", f, l_rdat, m_own[f] == 1 ? '0 : '1);
    cmp(tag, "right", f, r_rdat, m_own[f] == 2 ? '0 : '1);
  endtask

  task automatic rd_all(string tag);
    for (int f = 0; f < F; f++) rd(f, tag);
  endtask

  task automatic step(bit le, bit ls, bit lwe, int li, logic [W-1:0] ld,
                      bit re, bit rs, bit rwe, int ri, logic [W-1:0] rdv);
    @(negedge clk);
    l_en = le; l_sel_n = ls; l_we = lwe; l_idx = IW'(li); l_wdat = ld;
    r_en = re; r_sel_n = rs; r_we = rwe; r_idx = IW'(ri); r_wdat = rdv;
    @(posedge clk);
    model(le && !ls && lwe, li, ld[0], re && !rs && rwe, ri, rdv[0]);
    #1;
    l_we = 0; r_we = 0;
  endtask

  task automatic lw(int f, logic [W-1:0] d); step(1,0,1,f,d, 1,0,0,0,8'hFF); endtask
  task automatic rw(int f, logic [W-1:0] d); step(1,0,0,0,8'hFF, 1,0,1,f,d); endtask
  task automatic bw(int f, logic [W-1:0] dl, logic [W-1:0] dr); step(1,0,1,f,dl, 1,0,1,f,dr); endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    for (int f = 0; f < F; f++) begin m_own[f] = 0; m_pl[f] = 0; m_pr[f] = 0; m_tie[f] = 0; end
    l_en = 1; l_sel_n = 0; l_we = 0; l_idx = 0; l_wdat = '1;
    r_en = 1; r_sel_n = 0; r_we = 0; r_idx = 0; r_wdat = '1;
    repeat (3) @(posedge clk);
    #1 rd_all("R1");
    @(negedge clk) rst_n = 1;

    // R5 / R3: read in the write cycle shows the old state
    @(negedge clk);
    l_idx = 5; l_wdat = 8'h00; l_we = 1;
    #1 cmp("R3", "left", 5, l_rdat, '1);
    @(posedge clk); model(1, 5, 0, 0, 0, 1); #1 l_we = 0;
    rd(5, "R5");
    rw(5, 8'h00); rd(5, "R6");
    lw(5, 8'h01); rd(5, "R7");
    lw(5, 8'h01); rd(5, "R11");
    rw(5, 8'h00); rd(5, "R11");
    lw(5, 8'h00); lw(5, 8'hFF); rw(5, 8'h01); rd(5, "R9");
    lw(5, 8'h00); rw(5, 8'h01); rd(5, "R9");
    lw(5, 8'h01); rd(5, "R8");

    // R10 ties alternate per flag
    bw(2, 8'h00, 8'h00); rd(2, "R10");
    lw(2, 8'h01); rd(2, "R7");
    rw(2, 8'h01); rd(2, "R8");
    bw(2, 8'h00, 8'h00); rd(2, "R10");
    bw(3, 8'h00, 8'h00); rd(3, "R10");
    rw(2, 8'h01); lw(2, 8'h01); lw(3, 8'h01); rw(3, 8'h01); rd_all("R8");

    // R2 access qualifiers
    step(1,1,1,1,8'h00, 1,0,0,0,8'hFF); rd(1, "R2");
    step(0,0,1,1,8'h00, 1,0,0,0,8'hFF); rd(1, "R2");
    step(1,0,0,1,8'h00, 1,0,0,0,8'hFF); rd(1, "R2");
    lw(1, 8'h00);
    @(negedge clk) l_idx = 1; l_sel_n = 1; #1 cmp("R2", "left", 1, l_rdat, '1);
    l_sel_n = 0; l_en = 0; #1 cmp("R2", "left", 1, l_rdat, '1);
    lw(1, 8'hF1); rd(1, "R8");

    // R12 upper bits and neighbour flags
    lw(4, 8'hFE); rd_all("R12");
    rw(4, 8'h7E); lw(4, 8'h55); rd_all("R12");
    rw(4, 8'h01);

    // R7 same-cycle request and release
    lw(6, 8'h00);
    step(1,0,1,6,8'h01, 1,0,1,6,8'h00); rd(6, "R7");
    step(1,0,1,6,8'h00, 1,0,1,6,8'h01); rd(6, "R7");
    lw(6, 8'h01); rd(6, "R8");

    // sweep
    for (int n = 0; n < 4000; n++) begin
      int li = $urandom_range(0, F-1), ri = $urandom_range(0, F-1);
      bit lsn = ($urandom_range(0, 9) == 0), rsn = ($urandom_range(0, 9) == 0);
      bit len = ($urandom_range(0, 9) != 0), ren = ($urandom_range(0, 9) != 0);
      if ($urandom_range(0, 3) == 0) ri = li;
      step(len, lsn, $urandom_range(0, 3) != 0, li, W'($urandom),
           ren, rsn, $urandom_range(0, 3) != 0, ri, W'($urandom));
      rd(li, "R3");
      rd(ri, "R3");
      if (n % 32 == 31) rd_all("R4");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule